// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block collects the event pulses of an SD/MMC host's command and data engines into sticky, byte-wide status registers. Each flag stays set until software writes a one to its bit position. Per-bit mask bytes and one global enable bit reduce the flags to a single level-sensitive interrupt line. The block also samples the write-protect pin and the two possible card-detect pins. A chosen card-detect source, after a polarity correction, is shown as a live level. Every change of that level latches a device-inserted flag.

Software reaches the block through a small byte-addressed register port. Writes take effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. The 16-bit block-length register also lives here. It holds the block size minus one, the CRC-abort enable, the card-detect selection and polarity, and the global interrupt enable. Its size and abort fields are driven out to the data engine. A clock-freeze control bit is driven out to the clock generator.

Top module: `sdh_irq_stat`

## Requirements
- R1: After reset every register reads 0x00 at addresses 0 to 7, `irq` is low, `blk_len_m1` is 0, and `crc_abort` and `clk_freeze_en` are low. Address 3 is unused and always reads 0x00.
- R2: Event status (address 1) has these bits: 0 SDIO interrupt, 1 command/response done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error. A one-cycle pulse on `ev_flags[i]` sets bit i. The bit stays set with no further pulses.
- R3: A write to address 0 or address 1 clears each sticky bit whose data bit is 1. Bits written 0 are left as they are, so 0xFF clears every sticky bit in the byte.
- R4: If an event pulse arrives on the same cycle as a write that clears the same bit, the bit ends up set.
- R5: Card status (address 0) bit 5 is set by `ev_blk_done` and bit 4 by `ev_mblk_done`. Both are sticky and cleared by writing ones.
- R6: The following bits are live and ignore writes. In address 0: bit 1 is write protect, bit 2 is the DATA3 card-detect pin and bit 3 is the GPI card-detect pin, each after a `SYNC_STAGES` synchronizer. In address 2: bit 4 is `cmd_busy` and bit 5 is `dat_busy`. Address 2 bit 7 is a read/write bit that drives `clk_freeze_en`.
- R7: Address 0 bit 6 is the card-present level. The source is the GPI pin when block-length bit 13 is set. Otherwise it is the DATA3 pin when bit 14 is set. With neither bit set the level is 0. With a source selected, the level equals the pin when bit 12 is 1 and equals the inverted pin when bit 12 is 0.
- R8: Address 0 bit 7 (device inserted) is sticky. It is set on every change of the card-present level, whether a pin or the configuration caused the change.
- R9: The mask for address 1 is at address 5, where bits 7:1 are writable and bit 0 reads 0. The mask for address 0 is at address 4, where bits 7:4 are writable and bits 3:0 read 0.
- R10: `irq` is high exactly when block-length bit 15 is set and some bit of address 0 or address 1 is set together with its mask bit.
- R11: Block length is a 16-bit register, low byte at address 6 and high byte at address 7. Both bytes read back as written. Bits 10:0 drive `blk_len_m1` and bit 11 drives `crc_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ev_flags | input | 8 | Event pulses for the event status byte |
| ev_blk_done | input | 1 | Block-done pulse |
| ev_mblk_done | input | 1 | Multi-block-done pulse |
| cmd_busy | input | 1 | Live command/response busy |
| dat_busy | input | 1 | Live data-response busy |
| pin_wp | input | 1 | Write-protect pin (asynchronous) |
| pin_cd_dat3 | input | 1 | DATA3 card-detect pin (asynchronous) |
| pin_cd_gpi | input | 1 | GPI card-detect pin (asynchronous) |
| irq | output | 1 | Interrupt request, level |
| blk_len_m1 | output | 11 | Block size minus one |
| crc_abort | output | 1 | Abort transfer on CRC error |
| clk_freeze_en | output | 1 | Automatic clock-freeze enable |

## Verification
The hardest situation to reach is an event pulse that lands on exactly the clock edge where software clears the same flag. The stimulus drives the pulse and the clearing write on the same falling edge, once for each bit position. The device-inserted flag is the next hardest, because it can be set by a pin change under the old configuration and again by the configuration write itself. The bench sweeps every combination of polarity, source selection and pin levels. Before each step it clears the flag, and it predicts both possible transitions from its own model of the card-present level.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int BLK_SZ_W = 11;

  localparam logic [ADDR_W-1:0] A_CARD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVENT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK_C = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK_E = 3'd5;
  localparam logic [ADDR_W-1:0] A_BLK_LO = 3'd6;
  localparam logic [ADDR_W-1:0] A_BLK_HI = 3'd7;

  // sticky bits implemented in the card status byte
  localparam logic [BYTE_W-1:0] CARD_STICKY = 8'hB0;

  typedef struct packed {
    logic                gie;
    logic                dat3_sel;
    logic                gpi_sel;
    logic                pol_hi;
    logic                crc_abort;
    logic [BLK_SZ_W-1:0] size_m1;
  } blk_cfg_t;
endpackage

// File: rtl/sdh_sync.sv
module sdh_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdh_w1c_byte.sv
module sdh_w1c_byte #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (IMPL[b]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        q[b] <= 1'b0;
        else if (set_i[b]) q[b] <= 1'b1;   // event beats clear
        else if (clr_i[b]) q[b] <= 1'b0;
    end else begin : g_none
      assign q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/sdh_cd_track.sv
module sdh_cd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic gpi_s,
  input  logic dat3_s,
  input  logic gpi_sel,
  input  logic dat3_sel,
  input  logic pol_hi,
  output logic present,
  output logic changed
);
  logic raw;
  logic prev_q;

  assign raw     = gpi_sel ? gpi_s : dat3_s;
  assign present = (gpi_sel | dat3_sel) & ~(raw ^ pol_hi);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= present;

  assign changed = present ^ prev_q;
endmodule

// File: rtl/sdh_irq_stat.sv
module sdh_irq_stat
  import sdh_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  input  logic [BYTE_W-1:0]   ev_flags,
  input  logic                ev_blk_done,
  input  logic                ev_mblk_done,
  input  logic                cmd_busy,
  input  logic                dat_busy,
  input  logic                pin_wp,
  input  logic                pin_cd_dat3,
  input  logic                pin_cd_gpi,
  output logic                irq,
  output logic [BLK_SZ_W-1:0] blk_len_m1,
  output logic                crc_abort,
  output logic                clk_freeze_en
);
  localparam int BLK_W = 2 * BYTE_W;

  logic [2:0] pins_s;
  logic       wp_s, dat3_s, gpi_s;
  logic       cd_present, cd_changed;

  logic [BYTE_W-1:0] st0_q, st1_q, st0_set, st0_clr, st1_clr;
  logic [BYTE_W-1:0] card_view, mask_c_view, mask_e_view, ctrl_view;
  logic [3:0]        mask_c_q;
  logic [6:0]        mask_e_q;
  logic [BLK_W-1:0]  blk_q;
  logic              freeze_q;
  blk_cfg_t          cfg;

  logic hit_card, hit_event, hit_ctrl, hit_mc, hit_me, hit_lo, hit_hi;

  sdh_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pin_cd_gpi, pin_cd_dat3, pin_wp}),
    .q(pins_s)
  );
  assign {gpi_s, dat3_s, wp_s} = pins_s;

  assign cfg = blk_cfg_t'(blk_q);

  sdh_cd_track u_cd (
    .clk(clk), .rst_n(rst_n),
    .gpi_s(gpi_s), .dat3_s(dat3_s),
    .gpi_sel(cfg.gpi_sel), .dat3_sel(cfg.dat3_sel), .pol_hi(cfg.pol_hi),
    .present(cd_present), .changed(cd_changed)
  );

  assign hit_card  = reg_we && (reg_addr == A_CARD);
  assign hit_event = reg_we && (reg_addr == A_EVENT);
  assign hit_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign hit_mc    = reg_we && (reg_addr == A_MASK_C);
  assign hit_me    = reg_we && (reg_addr == A_MASK_E);
  assign hit_lo    = reg_we && (reg_addr == A_BLK_LO);
  assign hit_hi    = reg_we && (reg_addr == A_BLK_HI);

  assign st0_set = {cd_changed, 1'b0, ev_blk_done, ev_mblk_done, 4'b0000};
  assign st0_clr = hit_card  ? reg_wdata : '0;
  assign st1_clr = hit_event ? reg_wdata : '0;

  sdh_w1c_byte #(.WIDTH(BYTE_W), .IMPL(CARD_STICKY)) u_st_card (
    .clk(clk), .rst_n(rst_n), .set_i(st0_set), .clr_i(st0_clr), .q(st0_q)
  );

  sdh_w1c_byte #(.WIDTH(BYTE_W), .IMPL('1)) u_st_event (
    .clk(clk), .rst_n(rst_n), .set_i(ev_flags), .clr_i(st1_clr), .q(st1_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_c_q <= '0;
      mask_e_q <= '0;
      blk_q    <= '0;
      freeze_q <= 1'b0;
    end else begin
      if (hit_mc)   mask_c_q <= reg_wdata[7:4];
      if (hit_me)   mask_e_q <= reg_wdata[7:1];
      if (hit_lo)   blk_q[BYTE_W-1:0] <= reg_wdata;
      if (hit_hi)   blk_q[BLK_W-1:BYTE_W] <= reg_wdata;
      if (hit_ctrl) freeze_q <= reg_wdata[7];
    end
  end

  assign card_view   = {st0_q[7], cd_present, st0_q[5:4], gpi_s, dat3_s, wp_s, 1'b0};
  assign mask_c_view = {mask_c_q, 4'b0000};
  assign mask_e_view = {mask_e_q, 1'b0};
  assign ctrl_view   = {freeze_q, 1'b0, dat_busy, cmd_busy, 4'b0000};

  always_comb begin
    unique case (reg_addr)
      A_CARD:   reg_rdata = card_view;
      A_EVENT:  reg_rdata = st1_q;
      A_CTRL:   reg_rdata = ctrl_view;
      A_MASK_C: reg_rdata = mask_c_view;
      A_MASK_E: reg_rdata = mask_e_view;
      A_BLK_LO: reg_rdata = blk_q[BYTE_W-1:0];
      A_BLK_HI: reg_rdata = blk_q[BLK_W-1:BYTE_W];
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = cfg.gie &
               (|((card_view & mask_c_view) | (st1_q & mask_e_view)));

  assign blk_len_m1    = cfg.size_m1;
  assign crc_abort     = cfg.crc_abort;
  assign clk_freeze_en = freeze_q;
endmodule

// File: rtl/sdh_irq_stat_chk.sv
module sdh_irq_stat_chk
  import sdh_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] ev_flags,
  input logic              irq,
  input logic              gie,
  input logic              cd_present,
  input logic [BYTE_W-1:0] st0,
  input logic [BYTE_W-1:0] st1
);
  // R2
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flags != '0) |=> ((st1 & $past(ev_flags)) == $past(ev_flags)));

  // R2
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && ev_flags == '0) |=> $stable(st1));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EVENT && ev_flags == '0)
      |=> ((st1 & $past(reg_wdata)) == '0));

  // R4
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EVENT && ev_flags != '0)
      |=> ((st1 & $past(ev_flags)) == $past(ev_flags)));

  // R8
  ins_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cd_present) |=> st0[7]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);
endmodule

bind sdh_irq_stat sdh_irq_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_flags(ev_flags), .irq(irq), .gie(cfg.gie),
  .cd_present(cd_present), .st0(st0_q), .st1(st1_q)
);

// File: tb/tb_sdh_irq_stat.sv
module tb_sdh_irq_stat;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] ev_flags = '0;
  logic       ev_blk_done = 1'b0, ev_mblk_done = 1'b0;
  logic       cmd_busy = 1'b0, dat_busy = 1'b0;
  logic       pin_wp = 1'b0, pin_cd_dat3 = 1'b0, pin_cd_gpi = 1'b0;
  logic       irq;
  logic [10:0] blk_len_m1;
  logic       crc_abort, clk_freeze_en;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_irq_stat dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_flags(ev_flags),
    .ev_blk_done(ev_blk_done), .ev_mblk_done(ev_mblk_done),
    .cmd_busy(cmd_busy), .dat_busy(dat_busy), .pin_wp(pin_wp),
    .pin_cd_dat3(pin_cd_dat3), .pin_cd_gpi(pin_cd_gpi), .irq(irq),
    .blk_len_m1(blk_len_m1), .crc_abort(crc_abort),
    .clk_freeze_en(clk_freeze_en)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_ev(input logic [7:0] v);
    @(negedge clk); ev_flags = v;
    @(negedge clk); ev_flags = '0;
  endtask

  function automatic logic cd_model(input logic [7:0] hi, input logic gp, input logic dp);
    logic raw;
    raw = hi[5] ? gp : dp;
    return (hi[5] | hi[6]) & (raw == hi[4]);
  endfunction

  logic [7:0] r;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], r);
      chk("R1 reset read", {8'h0, r}, 16'h0);
    end
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 blk_len_m1", {5'h0, blk_len_m1}, 16'h0);
    chk("R1 abort/freeze", {14'h0, crc_abort, clk_freeze_en}, 16'h0);

    // R2 each event bit sets and stays
    for (int i = 0; i < 8; i++) begin
      pulse_ev(8'(1 << i));
      rd(3'd1, r);
      chk("R2 sticky accumulate", {8'h0, r}, 16'((1 << (i + 1)) - 1));
    end

    // R3 exhaustive write-one-to-clear on event byte
    for (int v = 0; v < 256; v++) begin
      pulse_ev(8'hFF);
      wr(3'd1, 8'(v));
      rd(3'd1, r);
      chk("R3 w1c event", {8'h0, r}, {8'h0, ~8'(v)});
    end
    wr(3'd1, 8'hFF);

    // R4 event and clear on the same edge
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, 8'hFF);
      @(negedge clk);
      ev_flags = 8'(1 << i);
      reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'hFF;
      @(negedge clk);
      ev_flags = '0; reg_we = 1'b0;
      rd(3'd1, r);
      chk("R4 event beats clear", {8'h0, r}, 16'(1 << i));
    end
    wr(3'd1, 8'hFF);

    // R5 block-done / multi-block-done
    @(negedge clk); ev_blk_done = 1'b1;
    @(negedge clk); ev_blk_done = 1'b0;
    rd(3'd0, r); chk("R5 blk done", {8'h0, r}, 16'h0020);
    @(negedge clk); ev_mblk_done = 1'b1;
    @(negedge clk); ev_mblk_done = 1'b0;
    rd(3'd0, r); chk("R5 mblk done", {8'h0, r}, 16'h0030);
    wr(3'd0, 8'h10);
    rd(3'd0, r); chk("R5 partial clear", {8'h0, r}, 16'h0020);
    wr(3'd0, 8'hFF);
    rd(3'd0, r); chk("R5 full clear", {8'h0, r}, 16'h0000);

    // R6 live bits
    pin_wp = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd0, r); chk("R6 write protect", {8'h0, r}, 16'h0002);
    wr(3'd0, 8'hFF);
    rd(3'd0, r); chk("R6 live ignores write", {8'h0, r}, 16'h0002);
    pin_cd_dat3 = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd0, r); chk("R6 dat3 pin", {8'h0, r}, 16'h0006);
    pin_cd_gpi = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd0, r); chk("R6 gpi pin", {8'h0, r}, 16'h000E);
    cmd_busy = 1'b1;
    rd(3'd2, r); chk("R6 cmd busy", {8'h0, r}, 16'h0010);
    dat_busy = 1'b1;
    rd(3'd2, r); chk("R6 dat busy", {8'h0, r}, 16'h0030);
    wr(3'd2, 8'hFF);
    rd(3'd2, r); chk("R6 freeze bit", {8'h0, r}, 16'h00B0);
    chk("R6 freeze out", {15'h0, clk_freeze_en}, 16'h1);
    wr(3'd2, 8'h00);
    cmd_busy = 1'b0; dat_busy = 1'b0;
    rd(3'd2, r); chk("R6 ctrl cleared", {8'h0, r}, 16'h0000);
    pin_wp = 1'b0; pin_cd_dat3 = 1'b0; pin_cd_gpi = 1'b0;
    repeat (5) @(negedge clk);
    wr(3'd0, 8'hFF);

    // R7 / R8 card-detect source, polarity and insertion flag
    begin
      logic [7:0] old_hi, new_hi;
      logic p0, p1, p2, gp, dp;
      old_hi = 8'h00; p0 = 1'b0;
      for (int c = 0; c < 32; c++) begin
        gp = c[3]; dp = c[4];
        new_hi = {1'b0, c[2], c[1], c[0], 4'b0000};
        wr(3'd0, 8'h80);
        pin_cd_gpi = gp; pin_cd_dat3 = dp;
        repeat (5) @(negedge clk);
        p1 = cd_model(old_hi, gp, dp);
        wr(3'd7, new_hi);
        repeat (3) @(negedge clk);
        p2 = cd_model(new_hi, gp, dp);
        rd(3'd0, r);
        chk("R7 R8 card detect", {8'h0, r},
            {8'h0, (p0 != p1) | (p1 != p2), p2, 2'b00, gp, dp, 2'b00});
        p0 = p2; old_hi = new_hi;
      end
      wr(3'd7, 8'h00);
      pin_cd_gpi = 1'b0; pin_cd_dat3 = 1'b0;
      repeat (5) @(negedge clk);
      wr(3'd0, 8'hFF);
      rd(3'd0, r); chk("R8 insertion cleared", {8'h0, r}, 16'h0000);
    end

    // R9 mask widths
    wr(3'd5, 8'hFF); rd(3'd5, r); chk("R9 event mask", {8'h0, r}, 16'h00FE);
    wr(3'd4, 8'hFF); rd(3'd4, r); chk("R9 card mask", {8'h0, r}, 16'h00F0);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);

    // R10 interrupt from event byte
    for (int p = 0; p < 3; p++) begin
      logic [7:0] pat;
      pat = (p == 0) ? 8'h01 : (p == 1) ? 8'h80 : 8'h55;
      wr(3'd1, 8'hFF);
      pulse_ev(pat);
      for (int m = 0; m < 256; m++) begin
        wr(3'd5, 8'(m));
        for (int g = 0; g < 2; g++) begin
          wr(3'd7, {g[0], 7'h00});
          chk("R10 irq event", {15'h0, irq},
              {15'h0, g[0] & (|(pat & 8'(m) & 8'hFE))});
        end
      end
    end
    wr(3'd1, 8'hFF); wr(3'd5, 8'h00);

    // R10 interrupt from card byte
    @(negedge clk); ev_blk_done = 1'b1;
    @(negedge clk); ev_blk_done = 1'b0;
    for (int n = 0; n < 16; n++) begin
      wr(3'd4, {4'(n), 4'h0});
      for (int g = 0; g < 2; g++) begin
        wr(3'd7, {g[0], 7'h00});
        chk("R10 irq card", {15'h0, irq},
            {15'h0, g[0] & (|(8'h20 & {4'(n), 4'h0}))});
      end
    end
    wr(3'd7, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'hFF);

    // R11 block length sweep
    for (int s = 0; s < 2048; s++) begin
      wr(3'd6, s[7:0]);
      wr(3'd7, {4'b0000, s[0], s[10:8]});
      chk("R11 size out", {5'h0, blk_len_m1}, 16'(s));
      chk("R11 abort out", {15'h0, crc_abort}, {15'h0, s[0]});
    end
    wr(3'd6, 8'h34); wr(3'd7, 8'h0D);
    rd(3'd6, r); chk("R11 low readback", {8'h0, r}, 16'h0034);
    rd(3'd7, r); chk("R11 high readback", {8'h0, r}, 16'h000D);
    chk("R11 size value", {5'h0, blk_len_m1}, 16'h0534);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule